// File: doc/BRIEF.md
# Shared Memory Local Lock Arbiter

This block decides which of two requesters may use a single-port shared memory: a local processor port and a slave window that serves masters on an external bus. Each side raises a request, receives a grant that it keeps until its access ends, and signals the end with a one-cycle done pulse. The external side can also mark an access as one part of an indivisible read-modify-write sequence. The grant then stays with the external side until the sequence ends.

Software holds a lock bit that gives the local side exclusive use of the memory. While the bit is set, external requests wait and are not granted. Local requests are still served. The lock has no timer. Only a software write changes it, so no other event and no abandoned external request releases it. A status output shows when an external request is waiting only because of the lock. When the lock is clear and both sides ask in the same cycle, the external side goes first.

Top module: `shm_lock_arb`

## Requirements
- R1: After a synchronous active-low reset, lock_q, ext_gnt, loc_gnt and ext_stall are all 0.
- R2: lock_q takes the value of lock_wdata at the clock edge where lock_wr is 1. When lock_wr is 0, lock_q keeps its value whatever lock_wdata carries.
- R3: Only a lock write changes lock_q. A stalled external request that is withdrawn, or done pulses and local traffic, leave the lock set.
- R4: While lock_q is 1, an external request that does not already hold the grant is not granted, and ext_stall is 1 for as long as that request stays up.
- R5: The lock has no timeout. An external request stays stalled for hundreds of cycles while the bit stays set.
- R6: With lock_q at 0 and both requests arriving in the same cycle from idle, ext_gnt is set first. loc_gnt follows after the external access has finished.
- R7: An external access that already holds the grant when the lock is set keeps ext_gnt until its done pulse, and ext_stall stays 0 during that time.
- R8: An external request that the lock has held is granted in the cycle after lock_q falls to 0.
- R9: While ext_rmw is 1, an ext_done pulse does not release ext_gnt, and the local side is not granted. The grant is released at the first ext_done with ext_rmw at 0.
- R10: ext_gnt and loc_gnt are never 1 together. A grant falls in the cycle after its releasing done pulse.
- R11: While lock_q is 1, a local request is granted and served normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_wr | input | 1 | Software write strobe for the lock bit |
| lock_wdata | input | 1 | Value written to the lock bit |
| lock_q | output | 1 | Current lock bit |
| ext_req | input | 1 | External slave window requests the memory |
| ext_rmw | input | 1 | External access belongs to an indivisible read-modify-write sequence |
| ext_done | input | 1 | One-cycle pulse that ends the current external access |
| ext_gnt | output | 1 | External side owns the memory |
| loc_req | input | 1 | Local processor requests the memory |
| loc_done | input | 1 | One-cycle pulse that ends the current local access |
| loc_gnt | output | 1 | Local side owns the memory |
| ext_stall | output | 1 | External request is waiting only because the lock is set |

## Verification
The grants are tried under several patterns. A lone external request arrives while the lock is held. Both sides request together with the lock clear, which shows the external-first order. An external access is already running when the lock is set, which separates an access in progress from a new arbitration decision. A read-modify-write sequence spans several done pulses, which separates a sequence boundary from a plain access end. A long wait under the lock and a withdrawn stalled request show that nothing but a lock write releases the bit. A clear with a held request pending pins the grant to the following cycle.

// File: rtl/shm_lock_pkg.sv
// Package shm_lock_pkg
// Holds the types that the arbiter pieces share.
// Assumes: exactly two requesters (external window and local port).
package shm_lock_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_EXT  = 2'd1,
        OWN_LOC  = 2'd2
    } owner_e;

endpackage

// File: rtl/shm_lock_ctrl.sv
// Module shm_lock_ctrl
// Holds the software lock bit. Only a lock write changes it. It has no
// timer and no hardware clear path.
// Assumes: lock_wr is a one-cycle strobe from the register decode.
module shm_lock_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_wr,
    input  logic lock_wdata,
    output logic lock_q
);

    // Lock bit register: loaded by software writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (lock_wr) begin
            lock_q <= lock_wdata;
        end
    end

endmodule

// File: rtl/shm_arb_core.sv
// Module shm_arb_core
// Ownership state machine for the shared memory. From idle it grants the
// external side when the lock is clear, and otherwise the local side.
// An owner keeps the memory until its done pulse. An external owner in a
// read-modify-write sequence keeps it through intermediate done pulses.
// Assumes: done pulses are raised only by the current owner.
module shm_arb_core
    import shm_lock_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lock_q,
    input  logic   ext_req,
    input  logic   ext_rmw,
    input  logic   ext_done,
    input  logic   loc_req,
    input  logic   loc_done,
    output owner_e owner
);

    owner_e owner_nxt;
    logic   ext_release;
    logic   loc_release;

    // Release conditions: the external side releases only at a sequence end.
    always_comb begin
        ext_release = ext_done && !ext_rmw;
        loc_release = loc_done;
    end

    // Next-owner decision: external first when unlocked, local otherwise.
    always_comb begin
        owner_nxt = owner;
        unique case (owner)
            OWN_NONE: begin
                if (ext_req && !lock_q) begin
                    owner_nxt = OWN_EXT;
                end else if (loc_req) begin
                    owner_nxt = OWN_LOC;
                end
            end
            OWN_EXT: begin
                if (ext_release) begin
                    owner_nxt = OWN_NONE;
                end
            end
            OWN_LOC: begin
                if (loc_release) begin
                    owner_nxt = OWN_NONE;
                end
            end
            default: owner_nxt = OWN_NONE;
        endcase
    end

    // Owner register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= OWN_NONE;
        end else begin
            owner <= owner_nxt;
        end
    end

endmodule

// File: rtl/shm_stall_mon.sv
// Module shm_stall_mon
// Reports an external request that waits only because of the lock.
// Assumes: the owner comes from a registered source, so the flag follows
// ext_req within the same cycle.
module shm_stall_mon
    import shm_lock_pkg::*;
(
    input  logic   lock_q,
    input  logic   ext_req,
    input  owner_e owner,
    output logic   ext_stall
);

    // Stall flag: external request pending, lock set, external side not owner.
    always_comb begin
        ext_stall = ext_req && lock_q && (owner != OWN_EXT);
    end

endmodule

// File: rtl/shm_lock_arb.sv
// Module shm_lock_arb (top)
// Arbitrates one single-port shared memory between an external slave window
// and a local processor port. A software lock bit holds external requests
// so that local accesses cannot be interleaved with external ones.
// Assumes: requesters hold req until granted, and pulse done for one cycle
// while they hold the grant.
module shm_lock_arb
    import shm_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_wr,
    input  logic lock_wdata,
    output logic lock_q,
    input  logic ext_req,
    input  logic ext_rmw,
    input  logic ext_done,
    output logic ext_gnt,
    input  logic loc_req,
    input  logic loc_done,
    output logic loc_gnt,
    output logic ext_stall
);

    owner_e owner;

    shm_lock_ctrl u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_wr    (lock_wr),
        .lock_wdata (lock_wdata),
        .lock_q     (lock_q)
    );

    shm_arb_core u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_q   (lock_q),
        .ext_req  (ext_req),
        .ext_rmw  (ext_rmw),
        .ext_done (ext_done),
        .loc_req  (loc_req),
        .loc_done (loc_done),
        .owner    (owner)
    );

    shm_stall_mon u_stall (
        .lock_q    (lock_q),
        .ext_req   (ext_req),
        .owner     (owner),
        .ext_stall (ext_stall)
    );

    // Grant decode from the registered owner.
    always_comb begin
        ext_gnt = (owner == OWN_EXT);
        loc_gnt = (owner == OWN_LOC);
    end

endmodule

// File: rtl/shm_lock_arb_chk.sv
// Module shm_lock_arb_chk
// Temporal checks on the arbiter ports, attached to shm_lock_arb by bind.
// Assumes: the same clock and reset as the design.
module shm_lock_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic lock_wr,
    input logic lock_q,
    input logic ext_req,
    input logic ext_rmw,
    input logic ext_done,
    input logic ext_gnt,
    input logic loc_gnt,
    input logic ext_stall
);

    AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_gnt && loc_gnt)); // R10

    AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_wr |=> $stable(lock_q)); // R3

    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q && !ext_gnt |=> !ext_gnt); // R4

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ext_gnt && !(ext_done && !ext_rmw) |=> ext_gnt); // R7

    AST_RMW_NO_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        ext_gnt && ext_rmw |=> !loc_gnt); // R9

    AST_EXT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_gnt && ext_done && !ext_rmw |=> !ext_gnt); // R10

    AST_UNLOCK_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) && ext_req && !ext_gnt && !loc_gnt |=> ext_gnt); // R8

    AST_STALL_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        ext_stall |-> !ext_gnt); // R7

endmodule

bind shm_lock_arb shm_lock_arb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_wr   (lock_wr),
    .lock_q    (lock_q),
    .ext_req   (ext_req),
    .ext_rmw   (ext_rmw),
    .ext_done  (ext_done),
    .ext_gnt   (ext_gnt),
    .loc_gnt   (loc_gnt),
    .ext_stall (ext_stall)
);

// File: tb/shm_lock_arb_tb_top.sv
// Bench shm_lock_arb_tb_top
// Scoreboard bench. The driver pushes the expected outputs for each sampled
// cycle into a queue. The monitor pops each item at once and compares it
// with the design's ports. Sampling and driving happen at the falling edge.
module shm_lock_arb_tb_top;

    typedef struct {
        string tag;
        logic  eg;
        logic  lg;
        logic  st;
        logic  lk;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_wr = 1'b0;
    logic lock_wdata = 1'b0;
    logic lock_q;
    logic ext_req = 1'b0;
    logic ext_rmw = 1'b0;
    logic ext_done = 1'b0;
    logic ext_gnt;
    logic loc_req = 1'b0;
    logic loc_done = 1'b0;
    logic loc_gnt;
    logic ext_stall;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    // 50 MHz clock.
    always #10 clk = ~clk;

    shm_lock_arb dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_wr    (lock_wr),
        .lock_wdata (lock_wdata),
        .lock_q     (lock_q),
        .ext_req    (ext_req),
        .ext_rmw    (ext_rmw),
        .ext_done   (ext_done),
        .ext_gnt    (ext_gnt),
        .loc_req    (loc_req),
        .loc_done   (loc_done),
        .loc_gnt    (loc_gnt),
        .ext_stall  (ext_stall)
    );

    // Advance to the next falling edge.
    task automatic nxt();
        @(negedge clk);
    endtask

    // Push the expected outputs for this falling edge, then step off it.
    task automatic expect_out(input string tag, input logic eg, input logic lg,
                              input logic st, input logic lk);
        exp_t it;
        it.tag = tag; it.eg = eg; it.lg = lg; it.st = st; it.lk = lk;
        exp_q.push_back(it);
        #2;
    endtask

    // Monitor: compare each expected item with the ports in the same timestep.
    initial begin
        forever begin
            exp_t it;
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            checks++;
            if (ext_gnt !== it.eg || loc_gnt !== it.lg ||
                ext_stall !== it.st || lock_q !== it.lk) begin
                errors++;
                $display("FAIL %s: got ext_gnt=%b loc_gnt=%b ext_stall=%b lock_q=%b, expected %b %b %b %b",
                         it.tag, ext_gnt, loc_gnt, ext_stall, lock_q,
                         it.eg, it.lg, it.st, it.lk);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected end of stimulus");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) nxt();
        expect_out("R1 reset state", 0, 0, 0, 0);
        rst_n = 1'b1;

        // R2: data without a strobe does nothing.
        nxt(); lock_wdata = 1'b1;
        nxt(); expect_out("R2 no strobe", 0, 0, 0, 0);
        lock_wr = 1'b1;
        nxt(); expect_out("R2 lock set", 0, 0, 0, 1);
        lock_wr = 1'b0; lock_wdata = 1'b0;

        // R4 and R11: external stalls, local is served while locked.
        ext_req = 1'b1; loc_req = 1'b1;
        nxt(); expect_out("R4 R11 locked ext stalls, local granted", 0, 1, 1, 1);
        loc_done = 1'b1; loc_req = 1'b0;
        nxt(); expect_out("R10 local released", 0, 0, 1, 1);
        loc_done = 1'b0;

        // R5: no timeout.
        repeat (300) nxt();
        expect_out("R5 still stalled after long wait", 0, 0, 1, 1);

        // R3: withdrawing the stalled request leaves the lock set.
        ext_req = 1'b0;
        nxt(); expect_out("R3 withdrawn request", 0, 0, 0, 1);
        nxt(); expect_out("R3 lock kept", 0, 0, 0, 1);
        ext_req = 1'b1;

        // R8: clear the lock with a held request.
        lock_wr = 1'b1; lock_wdata = 1'b0;
        nxt(); expect_out("R8 lock cleared", 0, 0, 0, 0);
        lock_wr = 1'b0;
        nxt(); expect_out("R8 held request granted", 1, 0, 0, 0);
        ext_done = 1'b1; ext_req = 1'b0;
        nxt(); expect_out("R10 ext released", 0, 0, 0, 0);
        ext_done = 1'b0;

        // R6: simultaneous requests, lock clear.
        ext_req = 1'b1; loc_req = 1'b1;
        nxt(); expect_out("R6 external first", 1, 0, 0, 0);
        ext_done = 1'b1; ext_req = 1'b0;
        nxt(); expect_out("R6 gap after ext", 0, 0, 0, 0);
        ext_done = 1'b0;
        nxt(); expect_out("R6 local next", 0, 1, 0, 0);
        loc_done = 1'b1; loc_req = 1'b0;
        nxt(); expect_out("R10 local released", 0, 0, 0, 0);
        loc_done = 1'b0;

        // R7: lock written during an external access.
        ext_req = 1'b1;
        nxt(); expect_out("R7 ext granted", 1, 0, 0, 0);
        lock_wr = 1'b1; lock_wdata = 1'b1;
        nxt(); expect_out("R7 access continues under lock", 1, 0, 0, 1);
        lock_wr = 1'b0;
        nxt(); expect_out("R7 still owner", 1, 0, 0, 1);
        ext_done = 1'b1;
        nxt(); expect_out("R7 completed", 0, 0, 1, 1);
        ext_done = 1'b0;
        nxt(); expect_out("R4 new request stalls", 0, 0, 1, 1);
        ext_req = 1'b0; lock_wr = 1'b1; lock_wdata = 1'b0;
        nxt(); expect_out("R2 lock cleared", 0, 0, 0, 0);
        lock_wr = 1'b0;

        // R9: read-modify-write sequence keeps the grant.
        ext_req = 1'b1; ext_rmw = 1'b1; loc_req = 1'b1;
        nxt(); expect_out("R9 rmw granted", 1, 0, 0, 0);
        ext_done = 1'b1;
        nxt(); expect_out("R9 held across first done", 1, 0, 0, 0);
        ext_done = 1'b0;
        nxt(); expect_out("R9 still held", 1, 0, 0, 0);
        ext_done = 1'b1; ext_rmw = 1'b0; ext_req = 1'b0;
        nxt(); expect_out("R9 released at sequence end", 0, 0, 0, 0);
        ext_done = 1'b0;
        nxt(); expect_out("R9 local after sequence", 0, 1, 0, 0);
        loc_done = 1'b1; loc_req = 1'b0;
        nxt(); expect_out("R10 final release", 0, 0, 0, 0);
        loc_done = 1'b0;

        repeat (2) nxt();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule